// File: doc/BRIEF.md
# Complementary PWM Generator with Dead Time

This block drives one half-bridge from a 16-bit time base. It produces a complementary pair, a high-side drive and a low-side drive. Between the moment one side switches off and the moment the other side switches on, both are held low for a programmable number of clock cycles. The counter can run edge-aligned, counting up and wrapping, or center-aligned, counting up to the period and back down.

Period and compare values are written into shadow registers. The counter copies them into its working registers only at fixed points of the count, so software can change the carrier frequency or the duty cycle at any time without producing a broken pulse.

An active-low protection input is qualified against glitches. Once qualified, it latches a fault flag that forces both drives low until software clears the flag. The flag can raise an interrupt line, and that line can be masked.

Top module: `pwm_deadband_gen`

## Requirements
- R1: A write is taken when wr_en is high at a clock edge, and wr_addr selects the target. Address 0 holds the period shadow P, 1 the compare shadow C, 2 the dead time D (low 8 bits), and 3 the control register, where bit0 is run, bit1 selects center-aligned and bit2 is the fault interrupt enable. A write to address 4 with bit0 set is a fault clear. After reset every register is zero and pwm_hi, pwm_lo and irq are low. While run is 0, both drives stay low.
- R2: In edge-aligned mode the counter goes 0..P and wraps, so one period is P+1 cycles. The high-side request is active while the count is below C. C=0 gives only the low side, and C>P gives only the high side.
- R3: In center-aligned mode the counter goes up from 0 to P and back down, so one period is 2P cycles. For 1<=C<=P the high-side request lasts 2C-1 cycles per period.
- R4: After either drive turns off, both stay low for D cycles before the other turns on. Per period, pwm_hi is high for H-D cycles and pwm_lo for L-D cycles, where H and L are the request's high and low run lengths. The two drives are never high together.
- R5: A request run no longer than D cycles produces no pulse on the side that run would turn on.
- R6: A period write takes effect only when the counter next returns to zero. The period in progress keeps the old length.
- R7: In center-aligned mode the compare value is reloaded both at zero and at the peak. A compare write made during the up count therefore already changes the high run around the next zero.
- R8: In edge-aligned mode the compare value is reloaded only at zero. The pulse in progress keeps its width, and the next pulse uses the new value.
- R9: If fault_n is low at two or more consecutive clock edges, the fault flag is set and both drives are forced low within 5 cycles. A low level seen at only one edge is ignored.
- R10: The fault flag stays set after fault_n returns high, until a fault clear is written. A clear written while fault_n is still low has no effect.
- R11: irq follows the fault flag when the interrupt enable bit is set and stays low otherwise. The drives stay blocked either way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| fault_n | input | 1 | Active-low protection input, asynchronous |
| pwm_hi | output | 1 | High-side drive |
| pwm_lo | output | 1 | Low-side drive |
| irq | output | 1 | Fault interrupt, gated by the enable bit |

## Verification
The hardest case to reach from the ports is a compare reload at the peak of the center-aligned count, because only the length of the following high run shows it. The bench waits for a falling edge of pwm_hi, which always falls in the up count. It then writes a new compare value and times the next high run. That run is 11 cycles if the peak reload happened and 8 cycles if it did not. Duty and dead-time results are measured as counts over a whole number of periods, so they do not depend on the phase at which the measurement starts.

// File: rtl/pwmdb_pkg.sv
package pwmdb_pkg;

    typedef enum logic {
        WAVE_EDGE   = 1'b0,
        WAVE_CENTER = 1'b1
    } wave_e;

    typedef struct packed {
        logic  fault_ie;
        wave_e wave;
        logic  run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] ADR_PERIOD   = 3'd0;
    localparam logic [2:0] ADR_COMPARE  = 3'd1;
    localparam logic [2:0] ADR_DEADTIME = 3'd2;
    localparam logic [2:0] ADR_CONTROL  = 3'd3;
    localparam logic [2:0] ADR_FAULTCLR = 3'd4;

    // number of sampling stages ahead of the two-edge qualifier
    localparam int SYNC_STAGES = 3;

endpackage

// File: rtl/pwmdb_regs.sv
module pwmdb_regs
    import pwmdb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DB_W   = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  per_shadow,
    output logic [CNT_W-1:0]  cmp_shadow,
    output logic [DB_W-1:0]   dead_val,
    output ctrl_t             ctrl,
    output logic              fault_clr
);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [2:0] target);
        return a == ADDR_W'(target);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            per_shadow <= '0;
            cmp_shadow <= '0;
            dead_val   <= '0;
            ctrl       <= '0;
        end else if (wr_en) begin
            if (hit(wr_addr, ADR_PERIOD))   per_shadow <= wr_data;
            if (hit(wr_addr, ADR_COMPARE))  cmp_shadow <= wr_data;
            if (hit(wr_addr, ADR_DEADTIME)) dead_val   <= wr_data[DB_W-1:0];
            if (hit(wr_addr, ADR_CONTROL))  ctrl       <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    assign fault_clr = wr_en && hit(wr_addr, ADR_FAULTCLR) && wr_data[0];

endmodule

// File: rtl/pwmdb_timebase.sv
module pwmdb_timebase
    import pwmdb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  wave_e            wave,
    input  logic [CNT_W-1:0] per_shadow,
    input  logic [CNT_W-1:0] cmp_shadow,
    output logic             req_hi
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_nx, per_q, cmp_q;
    logic             down_q, down_nx;
    logic             at_zero, at_peak;

    always_comb begin
        cnt_nx  = cnt_q;
        down_nx = down_q;
        if (wave == WAVE_EDGE) begin
            down_nx = 1'b0;
            cnt_nx  = (cnt_q >= per_q) ? '0 : cnt_q + ONE;
        end else if (!down_q) begin
            if (cnt_q >= per_q) begin
                if (per_q <= ONE) begin
                    cnt_nx = '0;
                end else begin
                    cnt_nx  = cnt_q - ONE;
                    down_nx = 1'b1;
                end
            end else begin
                cnt_nx = cnt_q + ONE;
            end
        end else begin
            if (cnt_q <= ONE) begin
                cnt_nx  = '0;
                down_nx = 1'b0;
            end else begin
                cnt_nx = cnt_q - ONE;
            end
        end
    end

    // reload points are taken from the next count so new values cover whole phases
    assign at_zero = (cnt_nx == '0);
    assign at_peak = (wave == WAVE_CENTER) && !down_q && (cnt_q < per_q) && (cnt_nx == per_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            per_q  <= '0;
            cmp_q  <= '0;
        end else if (!run) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            per_q  <= per_shadow;
            cmp_q  <= cmp_shadow;
        end else begin
            cnt_q  <= cnt_nx;
            down_q <= down_nx;
            if (at_zero) begin
                per_q <= per_shadow;
                cmp_q <= cmp_shadow;
            end else if (at_peak) begin
                cmp_q <= cmp_shadow;
            end
        end
    end

    assign req_hi = run && (cnt_q < cmp_q);

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> (cnt_q <= per_q));

    // R3
    down_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        down_q |-> (cnt_q != '0));

    // R6
    period_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (per_q != $past(per_q))) |-> (cnt_q == '0));

    // R8
    edge_cmp_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (wave == WAVE_EDGE) && $past(wave == WAVE_EDGE)
         && (cmp_q != $past(cmp_q))) |-> (cnt_q == '0));

endmodule

// File: rtl/pwmdb_deadband.sv
module pwmdb_deadband #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            req_hi,
    input  logic [DB_W-1:0] dead_val,
    input  logic            kill,
    output logic            pwm_hi,
    output logic            pwm_lo
);

    logic            lvl_q;
    logic [DB_W-1:0] gap_q;
    logic            settled;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            gap_q <= '0;
        end else if (!run) begin
            lvl_q <= 1'b0;
            gap_q <= dead_val;
        end else if (req_hi != lvl_q) begin
            lvl_q <= req_hi;
            gap_q <= dead_val;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign settled = run && !kill && (gap_q == '0);
    assign pwm_hi  = settled && lvl_q;
    assign pwm_lo  = settled && !lvl_q;

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(pwm_hi && pwm_lo));

    // R4
    hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ((dead_val != '0) && $stable(dead_val) && $rose(pwm_hi)) |-> !$past(pwm_lo));

    // R4
    lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ((dead_val != '0) && $stable(dead_val) && $rose(pwm_lo)) |-> !$past(pwm_hi));

endmodule

// File: rtl/pwmdb_fault.sv
module pwmdb_fault
    import pwmdb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fault_n,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    logic [SYNC_STAGES-1:0] smp_q;
    logic                   qualified;

    always_ff @(posedge clk) begin
        if (rst) smp_q <= '1;
        else     smp_q <= {smp_q[SYNC_STAGES-2:0], fault_n};
    end

    // low at two consecutive sampled edges
    assign qualified = !smp_q[SYNC_STAGES-1] && !smp_q[SYNC_STAGES-2];

    always_ff @(posedge clk) begin
        if (rst)            flag <= 1'b0;
        else if (qualified) flag <= 1'b1;
        else if (clr)       flag <= 1'b0;
    end

    assign irq = flag && irq_en;

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R10
    clr_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (qualified && clr) |=> flag);

endmodule

// File: rtl/pwm_deadband_gen.sv
module pwm_deadband_gen
    import pwmdb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DB_W   = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              fault_n,
    output logic              pwm_hi,
    output logic              pwm_lo,
    output logic              irq
);

    logic [CNT_W-1:0] per_shadow, cmp_shadow;
    logic [DB_W-1:0]  dead_val;
    ctrl_t            ctrl;
    logic             fault_clr, fault_flag, req_hi;

    pwmdb_regs #(.CNT_W(CNT_W), .DB_W(DB_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .per_shadow(per_shadow), .cmp_shadow(cmp_shadow), .dead_val(dead_val),
        .ctrl(ctrl), .fault_clr(fault_clr)
    );

    pwmdb_timebase #(.CNT_W(CNT_W)) tb_i (
        .clk(clk), .rst(rst), .run(ctrl.run), .wave(ctrl.wave),
        .per_shadow(per_shadow), .cmp_shadow(cmp_shadow), .req_hi(req_hi)
    );

    pwmdb_deadband #(.DB_W(DB_W)) db_i (
        .clk(clk), .rst(rst), .run(ctrl.run), .req_hi(req_hi), .dead_val(dead_val),
        .kill(fault_flag), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );

    pwmdb_fault flt_i (
        .clk(clk), .rst(rst), .fault_n(fault_n), .clr(fault_clr),
        .irq_en(ctrl.fault_ie), .flag(fault_flag), .irq(irq)
    );

    // R9
    fault_off_chk: assert property (@(posedge clk) disable iff (rst)
        fault_flag |-> (!pwm_hi && !pwm_lo));

    // R1
    idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> (!pwm_hi && !pwm_lo));

endmodule

// File: tb/pwm_deadband_gen_tb_top.sv
module pwm_deadband_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fault_n = 1'b1;
    logic        pwm_hi, pwm_lo, irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_deadband_gen dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fault_n(fault_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ctl: bit0 run, bit1 center, bit2 irq enable
    task automatic cfg(input logic center, input int p, input int c, input int d, input logic ie);
        wr(3'd3, 16'd0);
        wr(3'd0, 16'(p));
        wr(3'd1, 16'(c));
        wr(3'd2, 16'(d));
        wr(3'd3, {13'd0, ie, center, 1'b1});
        idle(3 * (2 * p + 2) + d + 4);
    endtask

    task automatic measure(input int n, output int h, output int l, output int o);
        h = 0; l = 0; o = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_hi) h++;
            if (pwm_lo) l++;
            if (!pwm_hi && !pwm_lo) o++;
        end
    endtask

    task automatic wait_edge(input logic rising, output int t);
        logic p;
        p = pwm_hi;
        forever begin
            @(negedge clk);
            if (rising ? (pwm_hi && !p) : (!pwm_hi && p)) break;
            p = pwm_hi;
        end
        t = cyc;
    endtask

    task automatic t_reset();
        chk("R1 reset pwm_hi", int'(pwm_hi), 0);
        chk("R1 reset pwm_lo", int'(pwm_lo), 0);
        chk("R1 reset irq", int'(irq), 0);
    endtask

    task automatic t_edge();
        int h, l, o;
        cfg(1'b0, 9, 4, 0, 1'b0);
        measure(40, h, l, o);
        chk("R2 edge hi", h, 16); chk("R2 edge lo", l, 24); chk("R4 zero dead off", o, 0);
        cfg(1'b0, 9, 4, 2, 1'b0);
        measure(40, h, l, o);
        chk("R4 dead hi", h, 8); chk("R4 dead lo", l, 16); chk("R4 dead off", o, 16);
        cfg(1'b0, 9, 0, 0, 1'b0);
        measure(40, h, l, o);
        chk("R2 cmp0 hi", h, 0); chk("R2 cmp0 lo", l, 40);
        cfg(1'b0, 9, 12, 0, 1'b0);
        measure(40, h, l, o);
        chk("R2 cmp>P hi", h, 40); chk("R2 cmp>P lo", l, 0);
    endtask

    task automatic t_center();
        int h, l, o;
        cfg(1'b1, 8, 3, 1, 1'b0);
        measure(64, h, l, o);
        chk("R3 center hi", h, 16); chk("R3 center lo", l, 40); chk("R3 center off", o, 8);
    endtask

    task automatic t_short();
        int h, l, o;
        cfg(1'b0, 9, 2, 3, 1'b0);
        measure(40, h, l, o);
        chk("R5 short hi", h, 0); chk("R5 short lo", l, 20); chk("R5 short off", o, 20);
        cfg(1'b0, 9, 8, 3, 1'b0);
        measure(40, h, l, o);
        chk("R5 short lo side", l, 0); chk("R5 long hi side", h, 20);
    endtask

    task automatic t_period_shadow();
        int t0, t1, t2;
        cfg(1'b0, 9, 4, 0, 1'b0);
        wait_edge(1'b1, t0);
        wr(3'd0, 16'd19);
        wait_edge(1'b1, t1);
        wait_edge(1'b1, t2);
        chk("R6 old period kept", t1 - t0, 10);
        chk("R6 new period", t2 - t1, 20);
    endtask

    task automatic t_edge_cmp();
        int t0, t1, t2, t3;
        cfg(1'b0, 9, 4, 0, 1'b0);
        wait_edge(1'b1, t0);
        wr(3'd1, 16'd7);
        wait_edge(1'b0, t1);
        wait_edge(1'b1, t2);
        wait_edge(1'b0, t3);
        chk("R8 current pulse", t1 - t0, 4);
        chk("R8 next pulse", t3 - t2, 7);
    endtask

    task automatic t_center_cmp();
        int tf, t0, t1;
        cfg(1'b1, 8, 3, 0, 1'b0);
        wait_edge(1'b0, tf);
        wr(3'd1, 16'd6);
        wait_edge(1'b1, t0);
        wait_edge(1'b0, t1);
        chk("R7 peak reload run", t1 - t0, 11);
    endtask

    task automatic t_fault();
        int h, l, o;
        cfg(1'b0, 9, 4, 0, 1'b1);
        @(negedge clk); fault_n = 1'b0;
        @(negedge clk); fault_n = 1'b1;
        idle(6);
        chk("R9 glitch irq", int'(irq), 0);
        measure(10, h, l, o);
        chk("R9 glitch drive", h + l, 10);
        fault_n = 1'b0;
        idle(3);
        fault_n = 1'b1;
        idle(3);
        chk("R11 irq set", int'(irq), 1);
        measure(20, h, l, o);
        chk("R10 latched off", h + l, 0);
        fault_n = 1'b0;
        idle(5);
        wr(3'd4, 16'd1);
        idle(2);
        chk("R10 clear while low", int'(irq), 1);
        fault_n = 1'b1;
        idle(5);
        chk("R10 still set", int'(irq), 1);
        wr(3'd4, 16'd1);
        idle(3);
        chk("R10 cleared irq", int'(irq), 0);
        measure(10, h, l, o);
        chk("R10 drive resumes", h + l, 10);
        wr(3'd3, 16'd1);
        fault_n = 1'b0;
        idle(3);
        fault_n = 1'b1;
        idle(3);
        chk("R11 masked irq", int'(irq), 0);
        measure(10, h, l, o);
        chk("R11 masked still off", h + l, 0);
        wr(3'd4, 16'd1);
        idle(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_edge();
        t_center();
        t_short();
        t_period_shadow();
        t_edge_cmp();
        t_center_cmp();
        t_fault();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule